// File: doc/BRIEF.md
# UART Transmit Flow-Control Gate

This block sits beside a UART transmitter and decides, one character at a time, whether the transmitter may begin sending its next character. A six-bit source mask picks which flow-control inputs take part in the decision. The candidates are four modem-status levels (clear-to-send, carrier detect, data-set-ready and ring indicate), a software transmit-enable bit and a receive-side character flow state. When any selected source is low, the next start is held back. A character that is already being shifted out always runs to completion.

The block also produces the request-to-send output. In one mode it follows the level that the UART supplies. In the other mode it is driven from the receive FIFO fill level and drops once the FIFO is half full. A remote-loopback switch sends the incoming serial data straight back out on the transmit pin in place of the UART's own serial output.

The three configuration fields live in a register that is loaded through a single write strobe. All modem inputs are asynchronous and pass through a two-flop synchronizer before they reach the gate.

Top module: `ufc_txflow`

## Requirements
- R1: After reset the source mask is 6'b010000 (bit 4 only), the RTS mode is 0 and loopback is off. With software enable high and every modem input low, the first start is therefore granted.
- R2: When `cfg_we` is high at a clock edge, the mask, the RTS mode and the loopback bit take the values on `cfg_mask`, `cfg_rts_auto` and `cfg_loop`, and they keep them until the next write.
- R3: Mask bit positions: 0 clear-to-send, 1 carrier detect, 2 data-set-ready, 3 ring indicate, 4 software enable, 5 receive flow state. If any enabled source is low, `tx_permit` is low. A change on `sw_tx_en` or `rx_flow_ok` reaches `tx_permit` one cycle after the edge that samples it. A change on a modem input reaches it three edges later: two synchronizer stages plus the permit register.
- R4: When the mask is all zeros, `tx_permit` is high whatever the sources do.
- R5: A source whose mask bit is 0 has no effect on `tx_permit`.
- R6: `tx_go` is high exactly when `tx_req` is high, `tx_busy` is low and `tx_permit` is high. A character in flight (`tx_busy` high) is never affected and never gets a grant.
- R7: In RTS mode 0, `rts_o` equals the `uart_rts` value that was sampled at the previous edge.
- R8: In RTS mode 1, `rts_o` is high exactly when the FIFO level sampled at the previous edge is below half the depth (32 for a depth of 64). In this mode `uart_rts` is ignored.
- R9: When loopback is on, `txd_o` equals `rxd_i`. When it is off, `txd_o` equals `uart_txd`. Both paths are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 6 | New flow-source mask |
| cfg_rts_auto | input | 1 | New RTS mode (1 = driven by FIFO level) |
| cfg_loop | input | 1 | New remote-loopback enable |
| cts_i | input | 1 | Clear-to-send level, asynchronous |
| dcd_i | input | 1 | Carrier-detect level, asynchronous |
| dsr_i | input | 1 | Data-set-ready level, asynchronous |
| ri_i | input | 1 | Ring-indicate level, asynchronous |
| sw_tx_en | input | 1 | Software transmit enable |
| rx_flow_ok | input | 1 | Receive character flow state (1 = go) |
| rx_fifo_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| uart_rts | input | 1 | RTS level requested by the UART |
| tx_req | input | 1 | UART has a character ready to start |
| tx_busy | input | 1 | UART is shifting a character out |
| rxd_i | input | 1 | Serial receive line |
| uart_txd | input | 1 | UART serial transmit data |
| tx_permit | output | 1 | Registered flow permission |
| tx_go | output | 1 | Start grant for the next character |
| rts_o | output | 1 | Request-to-send output |
| txd_o | output | 1 | Serial transmit line |

## Verification
The embedded assertions check several rules on every cycle. A grant never appears while a character is in flight. An all-zero mask always leads to permission. An enabled source that is low always blocks on the next cycle. RTS follows the selected mode with a one-cycle delay. The loopback mux routes the selected line. The exact three-edge latency of the modem inputs, the reset values of the configuration fields, and the level threshold at 31, 32 and 33 bytes are shown only by the bench's scenarios. There, a behavioural reference model is compared against every output on every clock.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
    localparam int NSRC      = 6;
    localparam int NMODEM    = 4;
    localparam int SRC_CTS   = 0;
    localparam int SRC_DCD   = 1;
    localparam int SRC_DSR   = 2;
    localparam int SRC_RI    = 3;
    localparam int SRC_SW    = 4;
    localparam int SRC_RXFC  = 5;
    localparam logic [NSRC-1:0] MASK_RESET = 6'b010000;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            rts_auto;
        logic            loop;
    } ufc_cfg_t;
endpackage

// File: rtl/ufc_sync.sv
module ufc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ufc_gate.sv
module ufc_gate
    import ufc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] src,
    input  logic            tx_req,
    input  logic            tx_busy,
    output logic            permit,
    output logic            tx_go
);
    logic permit_d, permit_q;
    logic [NSRC-1:0] blocked;

    always_comb begin
        blocked  = mask & ~src;
        permit_d = (blocked == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) permit_q <= 1'b0;
        else        permit_q <= permit_d;
    end

    assign permit = permit_q;
    assign tx_go  = tx_req & ~tx_busy & permit_q;

    a_r6_no_grant_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_go);
    a_r4_zero_mask_permits: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> permit);
    a_r3_enabled_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & ~src) != '0) |=> !permit);
endmodule

// File: rtl/ufc_rts.sv
module ufc_rts #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rts_auto,
    input  logic [LVL_W-1:0] level,
    input  logic             uart_rts,
    output logic             rts_o
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
    logic rts_d, rts_q;

    always_comb begin
        if (rts_auto) rts_d = (level < HALF);
        else          rts_d = uart_rts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_q <= 1'b0;
        else        rts_q <= rts_d;
    end

    assign rts_o = rts_q;

    a_r8_half_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto && level >= HALF) |=> !rts_o);
    a_r7_follow_uart: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto |=> (rts_o == $past(uart_rts)));
endmodule

// File: rtl/ufc_txflow.sv
module ufc_txflow
    import ufc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int STAGES = 2,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [NSRC-1:0]  cfg_mask,
    input  logic             cfg_rts_auto,
    input  logic             cfg_loop,
    input  logic             cts_i,
    input  logic             dcd_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             sw_tx_en,
    input  logic             rx_flow_ok,
    input  logic [LVL_W-1:0] rx_fifo_level,
    input  logic             uart_rts,
    input  logic             tx_req,
    input  logic             tx_busy,
    input  logic             rxd_i,
    input  logic             uart_txd,
    output logic             tx_permit,
    output logic             tx_go,
    output logic             rts_o,
    output logic             txd_o
);
    ufc_cfg_t cfg_d, cfg_q;
    logic [NMODEM-1:0] modem_async, modem_sync;
    logic [NSRC-1:0]   src;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.mask     = cfg_mask;
            cfg_d.rts_auto = cfg_rts_auto;
            cfg_d.loop     = cfg_loop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask     <= MASK_RESET;
            cfg_q.rts_auto <= 1'b0;
            cfg_q.loop     <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign modem_async = {ri_i, dsr_i, dcd_i, cts_i};

    ufc_sync #(.W(NMODEM), .STAGES(STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (modem_async),
        .sync_o  (modem_sync)
    );

    always_comb begin
        src           = '0;
        src[SRC_CTS]  = modem_sync[0];
        src[SRC_DCD]  = modem_sync[1];
        src[SRC_DSR]  = modem_sync[2];
        src[SRC_RI]   = modem_sync[3];
        src[SRC_SW]   = sw_tx_en;
        src[SRC_RXFC] = rx_flow_ok;
    end

    ufc_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask    (cfg_q.mask),
        .src     (src),
        .tx_req  (tx_req),
        .tx_busy (tx_busy),
        .permit  (tx_permit),
        .tx_go   (tx_go)
    );

    ufc_rts #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .rts_auto (cfg_q.rts_auto),
        .level    (rx_fifo_level),
        .uart_rts (uart_rts),
        .rts_o    (rts_o)
    );

    assign txd_o = cfg_q.loop ? rxd_i : uart_txd;

    a_r9_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
        txd_o == (cfg_q.loop ? rxd_i : uart_txd));
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q.mask == $past(cfg_mask)));
endmodule

// File: tb/test_ufc_txflow.sv
module test_ufc_txflow;
    localparam int PERIOD = 10;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_rts_auto = 0, cfg_loop = 0;
    logic [5:0] cfg_mask = '0;
    logic cts_i = 0, dcd_i = 0, dsr_i = 0, ri_i = 0, sw_tx_en = 0, rx_flow_ok = 0;
    logic [6:0] rx_fifo_level = '0;
    logic uart_rts = 0, tx_req = 0, tx_busy = 0, rxd_i = 0, uart_txd = 0;
    logic tx_permit, tx_go, rts_o, txd_o;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    // reference model state
    logic [5:0] m_mask = 6'b010000;
    logic m_auto = 0, m_loop = 0, m_permit = 0, m_rts = 0;
    logic [3:0] m_s1 = '0, m_s2 = '0;

    ufc_txflow i_ufc_txflow (.*);

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_mask <= 6'b010000; m_auto <= 0; m_loop <= 0;
            m_permit <= 0; m_rts <= 0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            logic [5:0] srcv;
            srcv = {rx_flow_ok, sw_tx_en, m_s2};
            m_s1 <= {ri_i, dsr_i, dcd_i, cts_i};
            m_s2 <= m_s1;
            m_permit <= &(srcv | ~m_mask);
            if (m_auto) m_rts <= (rx_fifo_level < 32);
            else        m_rts <= uart_rts;
            if (cfg_we) begin
                m_mask <= cfg_mask; m_auto <= cfg_rts_auto; m_loop <= cfg_loop;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3/R4/R5 permit", tx_permit, m_permit);
            chk("R6 go", tx_go, tx_req & ~tx_busy & m_permit);
            chk(m_auto ? "R8 rts" : "R7 rts", rts_o, m_rts);
            chk("R9 txd", txd_o, m_loop ? rxd_i : uart_txd);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(input logic [5:0] m, input logic a, input logic l);
        @(negedge clk);
        cfg_mask = m; cfg_rts_auto = a; cfg_loop = l; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
        cfg_mask = ~m; cfg_rts_auto = ~a; cfg_loop = ~l;
    endtask

    task automatic rnd_drive();
        {cts_i, dcd_i, dsr_i, ri_i} = 4'($urandom);
        sw_tx_en = 1'($urandom); rx_flow_ok = 1'($urandom);
        uart_rts = 1'($urandom); tx_req = 1'($urandom); tx_busy = 1'($urandom);
        rxd_i = 1'($urandom); uart_txd = 1'($urandom);
        rx_fifo_level = 7'($urandom_range(0, 64));
    endtask

    initial begin
        step(3);
        // R1: reset-state checks at ports
        chk("R1 rts after reset", rts_o, 1'b0);
        chk("R1 permit in reset", tx_permit, 1'b0);
        rst_n = 1;
        sw_tx_en = 1; rx_flow_ok = 0; tx_req = 1;
        step(2);
        chk("R1 default mask grants", tx_go, 1'b1);
        rxd_i = 1; uart_txd = 0; #1;
        chk("R1 loopback off", txd_o, 1'b0);
        // R3: modem latency, CTS enabled
        wcfg(6'b000001, 0, 0);
        cts_i = 0; step(4);
        chk("R3 cts low blocks", tx_permit, 1'b0);
        @(negedge clk); cts_i = 1;
        step(2);
        chk("R3 not yet after 2 edges", tx_permit, 1'b0);
        step(1);
        chk("R3 after 3 edges", tx_permit, 1'b1);
        // R5: disabled source toggling has no effect
        sw_tx_en = 0; rx_flow_ok = 0; dcd_i = 0; step(4);
        chk("R5 disabled ignored", tx_permit, 1'b1);
        // R4: zero mask
        wcfg(6'b000000, 0, 0);
        cts_i = 0; step(4);
        chk("R4 zero mask permits", tx_permit, 1'b1);
        // R6: in-flight
        tx_busy = 1; tx_req = 1; #1;
        chk("R6 busy no grant", tx_go, 1'b0);
        tx_busy = 0;
        // R8: threshold
        wcfg(6'b000000, 1, 0);
        uart_rts = 0;
        rx_fifo_level = 31; step(1); chk("R8 level 31", rts_o, 1'b1);
        rx_fifo_level = 32; step(1); chk("R8 level 32", rts_o, 1'b0);
        rx_fifo_level = 33; step(1); chk("R8 level 33", rts_o, 1'b0);
        uart_rts = 1; rx_fifo_level = 64; step(1); chk("R8 uart_rts ignored", rts_o, 1'b0);
        // R9: loopback on
        wcfg(6'b010000, 0, 1);
        rxd_i = 1; uart_txd = 0; #1;
        chk("R9 loopback on", txd_o, 1'b1);
        // R2 + all: random configs and stimulus, compared every clock
        for (int k = 0; k < 40; k++) begin
            wcfg(6'($urandom), 1'($urandom), 1'($urandom));
            for (int j = 0; j < 50; j++) begin
                @(negedge clk); rnd_drive();
            end
        end
        step(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule